// File: doc/BRIEF.md
# Transceiver TxD Line Encoder

This block drives the transmit data pin that runs from a protocol controller to a bus transceiver able to work in a slow and a fast mode. The controller hands over one bit per strobe. A flag sent with the strobe says whether that bit belongs to the high-speed data portion of a frame. Bits sent in slow mode go out as plain NRZ levels: a 0 drives the pin low (dominant) and a 1 leaves it high (recessive). Bits sent in fast mode go out as one pulse-width symbol each, and the fraction of the symbol spent high carries the bit value.

No extra control line tells the transceiver which mode to use. It works out the mode from the change in line coding alone. The controller raises the fast flag from the switch field into the data phase onward. It drops the flag again from the switch field back to arbitration, so that arbitration bits always go out as NRZ. The symbol length and the two high times are programmable and counted in system clocks. Each symbol is started by a strobe, and mode, bit and timing are captured at that moment. Stuffing, framing and arbitration are handled elsewhere.

Top module: `txd_line_encoder`

## Requirements
- R1: While reset is asserted, and on every cycle in which no symbol is in progress, `txd` is 1 (recessive).
- R2: A strobe accepted with `fast_req` = 0 drives `txd` to `bit_value` for Pe cycles, starting on the cycle after the strobe edge. Pe is the effective symbol length.
- R3: A strobe accepted with `fast_req` = 1 starts a PWM symbol of Pe cycles. `txd` is 0 for the first Pe−He cycles and 1 for the last He cycles. He comes from `cfg_hi0` when the bit is 0 and from `cfg_hi1` when the bit is 1.
- R4: The bit value, the mode and all three timing inputs are captured on the strobe edge. Changes to them during the symbol have no effect on that symbol.
- R5: Pe is `cfg_period`, with values below 2 raised to 2. He is the selected high time clamped to the range 1 to Pe−1, so every PWM symbol has both a low part and a high part.
- R6: A strobe in the last cycle of a symbol starts the next symbol right after it, with no idle cycle between. When no such strobe arrives, the block becomes idle after Pe cycles.
- R7: A strobe that arrives while a symbol is in progress, other than in its last cycle, is ignored.
- R8: The mode is chosen per symbol at a symbol boundary, so the coding switches from NRZ to PWM, and back, only between symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_strobe | input | 1 | One-cycle request to start a symbol for `bit_value` |
| bit_value | input | 1 | Bit to send, sampled with the strobe |
| fast_req | input | 1 | 1 selects PWM coding for this symbol, 0 selects NRZ |
| cfg_period | input | W | Symbol length in clocks |
| cfg_hi0 | input | W | High time of a PWM symbol carrying 0 |
| cfg_hi1 | input | W | High time of a PWM symbol carrying 1 |
| txd | output | 1 | Registered transmit data pin |

## Verification
The assertions assume that the timing inputs only matter at a strobe, and that a strobe is a free-running request the block may ignore. They therefore constrain no input and check only the symbol counter, the captured mode and the pin level. The stimulus sweeps every symbol length from 0 to 7 and every high time from 0 to 8, for both bit values and both modes. It places strobes either exactly in the last cycle of a symbol or after an idle gap. In the perturbed runs it flips the mode flag, the bit and the timing in the middle of a symbol and adds a stray strobe there. Those strobes stay clear of the last cycle, so the only strobes that count are the ones the requirements define.

// File: rtl/txd_enc_pkg.sv
package txd_enc_pkg;

    typedef enum logic {
        LINE_NRZ = 1'b0,
        LINE_PWM = 1'b1
    } line_mode_e;

    localparam int unsigned TXD_CNT_W_DEFAULT = 8;
    localparam int unsigned TXD_MIN_PERIOD    = 2;

endpackage

// File: rtl/txd_cfg_clamp.sv
// Turns raw timing inputs into the last counter index and the low-phase length
// of one symbol, both already limited to legal values.
module txd_cfg_clamp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] hi0_i,
    input  logic [W-1:0] hi1_i,
    input  logic         bit_i,
    output logic [W-1:0] last_idx_o,
    output logic [W-1:0] low_len_o
);
    import txd_enc_pkg::*;

    localparam logic [W-1:0] MIN_P = W'(TXD_MIN_PERIOD);

    logic [W-1:0] pe;
    logic [W-1:0] hsel;
    logic [W-1:0] he;

    always_comb begin
        pe   = (period_i < MIN_P) ? MIN_P : period_i;
        hsel = bit_i ? hi1_i : hi0_i;
        if (hsel == '0) begin
            he = W'(1);
        end else if (hsel > pe - W'(1)) begin
            he = pe - W'(1);
        end else begin
            he = hsel;
        end
        last_idx_o = pe - W'(1);
        low_len_o  = pe - he;
    end
endmodule

// File: rtl/txd_sym_step.sv
// Symbol counter stepping: accepts a strobe when idle or in the final cycle.
module txd_sym_step #(
    parameter int unsigned W = 8
) (
    input  logic         active_q,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] last_q,
    input  logic         strobe_i,
    output logic         accept_o,
    output logic         ending_o,
    output logic         active_d,
    output logic [W-1:0] cnt_d
);
    always_comb begin
        ending_o = active_q && (cnt_q == last_q);
        accept_o = strobe_i && (!active_q || ending_o);
        if (accept_o) begin
            active_d = 1'b1;
            cnt_d    = '0;
        end else if (ending_o) begin
            active_d = 1'b0;
            cnt_d    = '0;
        end else if (active_q) begin
            active_d = 1'b1;
            cnt_d    = cnt_q + W'(1);
        end else begin
            active_d = 1'b0;
            cnt_d    = '0;
        end
    end
endmodule

// File: rtl/txd_wave_gen.sv
// Pin level for one position inside a symbol, per coding.
module txd_wave_gen #(
    parameter int unsigned W = 8
) (
    input  txd_enc_pkg::line_mode_e mode_i,
    input  logic                    active_i,
    input  logic                    bit_i,
    input  logic [W-1:0]            cnt_i,
    input  logic [W-1:0]            low_len_i,
    output logic                    level_o
);
    import txd_enc_pkg::*;

    always_comb begin
        if (!active_i) begin
            level_o = 1'b1;
        end else if (mode_i == LINE_PWM) begin
            level_o = (cnt_i >= low_len_i);
        end else begin
            level_o = bit_i;
        end
    end
endmodule

// File: rtl/txd_line_encoder.sv
module txd_line_encoder #(
    parameter int unsigned W = txd_enc_pkg::TXD_CNT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_strobe,
    input  logic         bit_value,
    input  logic         fast_req,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_hi0,
    input  logic [W-1:0] cfg_hi1,
    output logic         txd
);
    import txd_enc_pkg::*;

    typedef struct packed {
        logic       active;
        line_mode_e mode;
        logic       bitv;
        logic [W-1:0] cnt;
        logic [W-1:0] last;
        logic [W-1:0] low_len;
        logic       txd;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic         accept;
    logic         ending;
    logic         step_active_d;
    logic [W-1:0] step_cnt_d;
    logic [W-1:0] clamp_last;
    logic [W-1:0] clamp_low;
    logic         wave_level;

    txd_cfg_clamp #(.W(W)) u_clamp (
        .period_i   (cfg_period),
        .hi0_i      (cfg_hi0),
        .hi1_i      (cfg_hi1),
        .bit_i      (bit_value),
        .last_idx_o (clamp_last),
        .low_len_o  (clamp_low)
    );

    txd_sym_step #(.W(W)) u_step (
        .active_q (st_q.active),
        .cnt_q    (st_q.cnt),
        .last_q   (st_q.last),
        .strobe_i (bit_strobe),
        .accept_o (accept),
        .ending_o (ending),
        .active_d (step_active_d),
        .cnt_d    (step_cnt_d)
    );

    txd_wave_gen #(.W(W)) u_wave (
        .mode_i    (st_d.mode),
        .active_i  (st_d.active),
        .bit_i     (st_d.bitv),
        .cnt_i     (st_d.cnt),
        .low_len_i (st_d.low_len),
        .level_o   (wave_level)
    );

    // next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.active = step_active_d;
        st_d.cnt    = step_cnt_d;
        if (accept) begin
            st_d.mode    = fast_req ? LINE_PWM : LINE_NRZ;
            st_d.bitv    = bit_value;
            st_d.last    = clamp_last;
            st_d.low_len = clamp_low;
        end else if (ending) begin
            st_d.mode = LINE_NRZ;
            st_d.bitv = 1'b1;
        end
        st_d.txd = wave_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.mode    <= LINE_NRZ;
            st_q.bitv    <= 1'b1;
            st_q.last    <= W'(1);
            st_q.low_len <= W'(1);
            st_q.txd     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd = st_q.txd;

    logic         sym_active;
    logic         sym_pwm;
    logic [W-1:0] sym_cnt;
    logic [W-1:0] sym_last;
    assign sym_active = st_q.active;
    assign sym_pwm    = (st_q.mode == LINE_PWM);
    assign sym_cnt    = st_q.cnt;
    assign sym_last   = st_q.last;

endmodule

// File: rtl/txd_line_encoder_chk.sv
module txd_line_encoder_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_strobe,
    input logic         txd,
    input logic         sym_active,
    input logic         sym_pwm,
    input logic [W-1:0] sym_cnt,
    input logic [W-1:0] sym_last
);
    // R1: idle pin is recessive
    a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_active |-> txd);

    // R2: NRZ level does not move inside a symbol
    a_r2_nrz_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_active && !sym_pwm && sym_cnt != '0) |-> $stable(txd));

    // R3: PWM symbol opens low and closes high
    a_r3_pwm_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_active && sym_pwm && sym_cnt == '0) |-> !txd);
    a_r3_pwm_closes_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_active && sym_pwm && sym_cnt == sym_last) |-> txd);

    // R8: coding only changes at a symbol boundary
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_active && sym_cnt != '0) |-> $stable(sym_pwm));

    // R5: counter stays inside a symbol of at least two cycles
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sym_active |-> (sym_cnt <= sym_last && sym_last >= W'(1)));

    // R7: mid-symbol strobe does not restart the counter
    a_r7_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_active && sym_cnt != sym_last && bit_strobe) |=>
            (sym_active && sym_cnt == $past(sym_cnt) + W'(1)));
endmodule

bind txd_line_encoder txd_line_encoder_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_strobe (bit_strobe),
    .txd        (txd),
    .sym_active (sym_active),
    .sym_pwm    (sym_pwm),
    .sym_cnt    (sym_cnt),
    .sym_last   (sym_last)
);

// File: tb/tb_txd_line_encoder.sv
module tb_txd_line_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_strobe = 1'b0;
    logic         bit_value = 1'b1;
    logic         fast_req = 1'b0;
    logic [W-1:0] cfg_period = 8'd4;
    logic [W-1:0] cfg_hi0 = 8'd1;
    logic [W-1:0] cfg_hi1 = 8'd3;
    logic         txd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txd_line_encoder #(.W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_strobe (bit_strobe),
        .bit_value  (bit_value),
        .fast_req   (fast_req),
        .cfg_period (cfg_period),
        .cfg_hi0    (cfg_hi0),
        .cfg_hi1    (cfg_hi1),
        .txd        (txd)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: txd=%b expected %b", req, $time, act, exp);
        end
    endtask

    // Expects to be called at a negedge; ends at the negedge of the symbol's last cycle.
    task automatic send_sym(input logic b, input logic f, input int p,
                            input int h0, input int h1, input bit perturb,
                            input string req);
        int pe;
        int hx;
        int he;
        logic exp;
        pe = (p < 2) ? 2 : p;
        hx = b ? h1 : h0;
        he = (hx < 1) ? 1 : ((hx > pe - 1) ? pe - 1 : hx);
        bit_strobe = 1'b1;
        bit_value  = b;
        fast_req   = f;
        cfg_period = W'(p);
        cfg_hi0    = W'(h0);
        cfg_hi1    = W'(h1);
        for (int j = 0; j < pe; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j == 0) bit_strobe = 1'b0;
            if (perturb && pe >= 3 && j == 1) begin
                bit_strobe = 1'b1;          // stray strobe, R7
                bit_value  = ~b;            // R4
                fast_req   = ~f;            // R4, R8
                cfg_period = W'(7 - p);
                cfg_hi0    = W'(h1 + 1);
                cfg_hi1    = W'(h0 + 2);
            end
            if (perturb && pe >= 3 && j == 2) bit_strobe = 1'b0;
            exp = f ? logic'(j >= pe - he) : b;
            check(txd, exp, req);
        end
    endtask

    task automatic idle(input int n);
        bit_strobe = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(txd, 1'b1, "R1/R6 idle after symbol");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(txd, 1'b1, "R1 reset");
        rst_n = 1'b1;
        idle(3);

        // R2 slow NRZ sweep, back-to-back per R6, lengths incl. clamp R5
        for (int p = 0; p < 8; p++) begin
            send_sym(1'b0, 1'b0, p, 1, 1, 1'b0, "R2 nrz");
            send_sym(1'b1, 1'b0, p, 1, 1, 1'b0, "R2 nrz");
            send_sym(1'b1, 1'b0, p, 1, 1, 1'b1, "R2/R4 nrz perturbed");
            send_sym(1'b0, 1'b0, p, 1, 1, 1'b1, "R2/R4 nrz perturbed");
            idle(1);
        end

        // R3 fast PWM sweep over lengths and high times, R5 clamps
        for (int p = 0; p < 8; p++) begin
            for (int h = 0; h < 9; h++) begin
                send_sym(1'b0, 1'b1, p, h, 8 - h, 1'b0, "R3/R5 pwm bit0");
                send_sym(1'b1, 1'b1, p, h, 8 - h, 1'b0, "R3/R5 pwm bit1");
                send_sym(1'b1, 1'b1, p, 8 - h, h, 1'b1, "R3/R4 pwm perturbed");
            end
            idle(2);
        end

        // R8: NRZ -> PWM -> NRZ switches at boundaries, back-to-back
        for (int p = 2; p < 7; p++) begin
            send_sym(1'b0, 1'b0, p, 1, p - 1, 1'b0, "R8 arb bit");
            send_sym(1'b1, 1'b0, p, 1, p - 1, 1'b0, "R8 arb bit");
            send_sym(1'b0, 1'b1, p, 1, p - 1, 1'b0, "R8 switch to pwm");
            send_sym(1'b1, 1'b1, p, 1, p - 1, 1'b1, "R8 pwm data");
            send_sym(1'b1, 1'b0, p, 1, p - 1, 1'b0, "R8 switch to nrz");
            send_sym(1'b0, 1'b0, p, 1, p - 1, 1'b0, "R8 nrz after data");
            idle(3);
        end

        // R1: reset in the low part of a PWM symbol forces recessive
        bit_strobe = 1'b1; bit_value = 1'b0; fast_req = 1'b1;
        cfg_period = 8'd6; cfg_hi0 = 8'd1; cfg_hi1 = 8'd5;
        @(posedge clk); @(negedge clk);
        bit_strobe = 1'b0;
        check(txd, 1'b0, "R3 pwm low phase before reset");
        rst_n = 1'b0;
        #1;
        check(txd, 1'b1, "R1 async reset mid symbol");
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        send_sym(1'b0, 1'b0, 3, 1, 1, 1'b0, "R2 nrz after reset");
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule